// File: doc/BRIEF.md
# Convolution Multiply-Accumulate Lane

This block is one lane of a convolution engine that handles both depthwise (kernel-window) and pointwise (channel-depth) layers. Each accepted beat carries up to MS×MS weight/feature pairs. The lane multiplies every pair in parallel and reduces the products through a registered adder tree. It then accumulates a runtime-selected number of beats into one wide partial sum. For depthwise work that number is ceil(K·K / MS²). For pointwise work it is ceil(IC / MS²).

When the last beat of a group leaves the tree, the lane adds that group's bias and shortcut (residual) to the sum. It then clamps the total to the range from zero to a runtime ceiling and emits one result. Operands, bias, shortcut, ceiling and result are 16-bit signed fixed point with 8 fraction bits. Products and sums keep 16 fraction bits in a 40-bit accumulator.

An upstream scheduler streams beats with any number of idle cycles between them. It pads short groups by clearing mask bits. It drives the shortcut to zero for layers that have no residual connection.

Top module: `conv_mac_lane`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0 and `out_data` is 0. A reset in the middle of a group discards that group's partial sum, so the next group starts from zero.
- R2: A beat contributes the sum of `w[i]*f[i]` over the pairs whose `in_mask[i]` bit is 1. Pair i occupies bits `[16*i +: 16]` of `in_wgt` and `in_feat`. Data on pairs whose mask bit is 0 has no effect on the result.
- R3: `acc_len` is sampled on the first beat of a group and sets how many beats form that group. A value of 0 counts as 1. The largest count is 255. Values of `acc_len` on the later beats of the group are ignored.
- R4: Cycles with `in_valid` low are ignored, whatever the data and control inputs carry. Idle cycles may fall between any two beats.
- R5: `bias` and `shortcut` are sampled on the final beat of a group only. Each is shifted left by 8 bits to accumulator scale and added to the group sum.
- R6: The residual is added before the clamp. The result is clamp(sum + bias + shortcut), not clamp(sum + bias) + shortcut.
- R7: The clamp maps a negative total to 0 and a total above `act_ceil` to `act_ceil`. `act_ceil` is a non-negative value in the operand format, sampled on the final beat. Every result is therefore non-negative.
- R8: Each group produces exactly one `out_valid` pulse. `out_data` is the clamped total shifted right by 8 bits (floor) and holds its value until the next result.
- R9: For MS=4, `out_valid` rises 5 rising edges after the edge that samples a group's final beat. In general the latency is log2ceil(MS²)+1.
- R10: A new group may start in the beat right after the final beat of the previous one, with no idle cycle, and it carries nothing over from that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_wgt | input | MS*MS*16 | Packed weights, pair i at bits [16*i +: 16] |
| in_feat | input | MS*MS*16 | Packed features, same packing |
| in_mask | input | MS*MS | Per-pair enable; 0 forces that product to zero |
| acc_len | input | 8 | Beats per group, sampled on the first beat |
| bias | input | 16 | Bias, sampled on the final beat |
| shortcut | input | 16 | Residual, sampled on the final beat |
| act_ceil | input | 16 | Clamp ceiling, sampled on the final beat |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Clamped result, 8 fraction bits |

## Verification
A stale or corrupted accumulator shows up in the first result after the fault, as a value offset from the dot-product model. A wrong beat count in the group counter shifts every later result. It appears as missing or extra `out_valid` pulses and as results that fold together the data of two groups. A misaligned side-band pipeline applies the wrong bias, shortcut or ceiling, or moves the strobe off its cycle. These errors appear within log2ceil(MS²)+1 cycles of the affected final beat.

// File: rtl/mac_lane_pkg.sv
// Package of elaboration-time helpers shared by the lane modules.
// Assumes only positive pair counts are passed in.
package mac_lane_pkg;

    // Number of pairwise adder levels needed to reduce n operands to one.
    function automatic int tree_depth(input int n);
        int d;
        d = 0;
        while ((1 << d) < n) d++;
        return d;
    endfunction

    // n rounded up to the next power of two (the padded tree width).
    function automatic int pad_pow2(input int n);
        return 1 << tree_depth(n);
    endfunction

endpackage

// File: rtl/mac_prod_tree.sv
// Parallel multiplier row followed by a registered binary adder tree.
// Masked pairs and the padding up to a power of two enter the tree as zero.
// A side-band tag and the valid bit travel with the data, so they emerge
// on the same cycle as the matching sum.
// Assumes NPAIR >= 2. Latency is tree_depth(NPAIR) + 1 cycles.
module mac_prod_tree
    import mac_lane_pkg::*;
#(
    parameter int NPAIR = 16,
    parameter int DW    = 16,
    parameter int ACCW  = 40,
    parameter int TAGW  = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [TAGW-1:0]        in_tag,
    input  logic [NPAIR*DW-1:0]    in_wgt,
    input  logic [NPAIR*DW-1:0]    in_feat,
    input  logic [NPAIR-1:0]       in_mask,
    output logic                   out_valid,
    output logic [TAGW-1:0]        out_tag,
    output logic signed [ACCW-1:0] out_sum
);
    localparam int NLEV = tree_depth(NPAIR);
    localparam int NP2  = pad_pow2(NPAIR);

    logic [NP2*DW-1:0]      wgt_pad;
    logic [NP2*DW-1:0]      feat_pad;
    logic [NP2-1:0]         mask_pad;
    logic signed [ACCW-1:0] prod_c [NP2];
    logic signed [ACCW-1:0] prod_q [NP2];
    logic [NLEV:0]          vld_q;
    logic [TAGW-1:0]        tag_q  [NLEV+1];

    assign wgt_pad  = (NP2*DW)'(in_wgt);
    assign feat_pad = (NP2*DW)'(in_feat);
    assign mask_pad = NP2'(in_mask);

    // Multiply every enabled pair; disabled and padding pairs give zero.
    always_comb begin
        for (int i = 0; i < NP2; i++) begin
            if (mask_pad[i])
                prod_c[i] = $signed(wgt_pad[i*DW +: DW]) * $signed(feat_pad[i*DW +: DW]);
            else
                prod_c[i] = '0;
        end
    end

    // Register the product row (pipeline stage 0).
    always_ff @(posedge clk) begin
        for (int i = 0; i < NP2; i++) begin
            if (!rst_n) prod_q[i] <= '0;
            else        prod_q[i] <= prod_c[i];
        end
    end

    // One registered adder level per generate step, halving the width.
    for (genvar l = 0; l < NLEV; l++) begin : g_lvl
        localparam int CNT = NP2 >> (l + 1);
        logic signed [ACCW-1:0] node [CNT];
        if (l == 0) begin : g_first
            // Sum adjacent products.
            always_ff @(posedge clk) begin
                for (int j = 0; j < CNT; j++) begin
                    if (!rst_n) node[j] <= '0;
                    else        node[j] <= prod_q[2*j] + prod_q[2*j+1];
                end
            end
        end else begin : g_next
            // Sum adjacent nodes of the previous level.
            always_ff @(posedge clk) begin
                for (int j = 0; j < CNT; j++) begin
                    if (!rst_n) node[j] <= '0;
                    else        node[j] <= g_lvl[l-1].node[2*j] + g_lvl[l-1].node[2*j+1];
                end
            end
        end
    end

    // Carry valid and tag alongside the data through every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k <= NLEV; k++) tag_q[k] <= '0;
        end else begin
            vld_q <= {vld_q[NLEV-1:0], in_valid};
            tag_q[0] <= in_tag;
            for (int k = 1; k <= NLEV; k++) tag_q[k] <= tag_q[k-1];
        end
    end

    assign out_valid = vld_q[NLEV];
    assign out_tag   = tag_q[NLEV];
    assign out_sum   = g_lvl[NLEV-1].node[0];

endmodule

// File: rtl/mac_group_ctrl.sv
// Counts accepted beats and flags the final beat of each accumulation group.
// The group length is captured on the first beat; a length of zero counts as one.
// Assumes the upstream holds in_valid low on idle cycles.
module mac_group_ctrl #(
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CNTW-1:0] acc_len,
    output logic            grp_last
);
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] len_q;
    logic [CNTW-1:0] len_eff;
    logic [CNTW-1:0] len_now;

    // Pick the live length: fresh input on a first beat, latched value afterwards.
    always_comb begin
        len_eff  = (acc_len == '0) ? CNTW'(1) : acc_len;
        len_now  = (cnt_q == '0) ? len_eff : len_q;
        grp_last = in_valid && ((cnt_q + CNTW'(1)) == len_now);
    end

    // Advance the beat counter and latch the length on first beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (in_valid) begin
            cnt_q <= grp_last ? '0 : cnt_q + CNTW'(1);
            if (cnt_q == '0) len_q <= len_eff;
        end
    end

endmodule

// File: rtl/mac_post.sv
// Wide accumulator and output stage. Tree sums are summed until the group's
// final beat arrives. The final beat adds bias and shortcut at accumulator
// scale, clamps to [0, ceiling], rescales to the operand format and clears the
// accumulator. Assumes a non-negative ceiling.
module mac_post #(
    parameter int DW   = 16,
    parameter int ACCW = 40,
    parameter int FRAC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_last,
    input  logic signed [ACCW-1:0] in_sum,
    input  logic [DW-1:0]          bias,
    input  logic [DW-1:0]          shortcut,
    input  logic [DW-1:0]          act_ceil,
    output logic                   out_valid,
    output logic [DW-1:0]          out_data
);
    logic signed [ACCW-1:0] acc_q;
    logic signed [ACCW-1:0] bias_x;
    logic signed [ACCW-1:0] sc_x;
    logic signed [ACCW-1:0] ceil_x;
    logic signed [ACCW-1:0] total;
    logic signed [ACCW-1:0] clamped;

    // Align side-band values to the accumulator scale, add residual, then clamp.
    always_comb begin
        bias_x = {{(ACCW-DW){bias[DW-1]}}, bias} << FRAC;
        sc_x   = {{(ACCW-DW){shortcut[DW-1]}}, shortcut} << FRAC;
        ceil_x = {{(ACCW-DW){act_ceil[DW-1]}}, act_ceil} << FRAC;
        total  = acc_q + in_sum + bias_x + sc_x;
        if (total < 0)
            clamped = '0;
        else if (total > ceil_x)
            clamped = ceil_x;
        else
            clamped = total;
    end

    // Accumulate partial sums; emit and clear on the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                if (in_last) begin
                    acc_q     <= '0;
                    out_valid <= 1'b1;
                    out_data  <= DW'(clamped >>> FRAC);
                end else begin
                    acc_q <= acc_q + in_sum;
                end
            end
        end
    end

endmodule

// File: rtl/conv_mac_lane.sv
// Top of the convolution MAC lane. The group counter tags the final beat.
// The product tree carries that tag, together with bias, shortcut and
// ceiling, beside the data. The post stage accumulates, adds the residual
// and clamps. Assumes MS is 3 or 4 and DW-bit operands with FRAC fraction bits.
module conv_mac_lane
    import mac_lane_pkg::*;
#(
    parameter int MS   = 4,
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int ACCW = 40,
    parameter int CNTW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [MS*MS*DW-1:0]   in_wgt,
    input  logic [MS*MS*DW-1:0]   in_feat,
    input  logic [MS*MS-1:0]      in_mask,
    input  logic [CNTW-1:0]       acc_len,
    input  logic [DW-1:0]         bias,
    input  logic [DW-1:0]         shortcut,
    input  logic [DW-1:0]         act_ceil,
    output logic                  out_valid,
    output logic [DW-1:0]         out_data
);
    localparam int NPAIR = MS * MS;
    localparam int TAGW  = 1 + 3 * DW;
    localparam int LAT   = tree_depth(NPAIR) + 1;

    logic                   grp_last;
    logic                   t_valid;
    logic [TAGW-1:0]        t_tag;
    logic signed [ACCW-1:0] t_sum;

    mac_group_ctrl #(.CNTW(CNTW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .acc_len  (acc_len),
        .grp_last (grp_last)
    );

    mac_prod_tree #(.NPAIR(NPAIR), .DW(DW), .ACCW(ACCW), .TAGW(TAGW)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_tag    ({grp_last, bias, shortcut, act_ceil}),
        .in_wgt    (in_wgt),
        .in_feat   (in_feat),
        .in_mask   (in_mask),
        .out_valid (t_valid),
        .out_tag   (t_tag),
        .out_sum   (t_sum)
    );

    mac_post #(.DW(DW), .ACCW(ACCW), .FRAC(FRAC)) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (t_valid),
        .in_last   (t_tag[TAGW-1]),
        .in_sum    (t_sum),
        .bias      (t_tag[3*DW-1:2*DW]),
        .shortcut  (t_tag[2*DW-1:DW]),
        .act_ceil  (t_tag[DW-1:0]),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/mac_lane_chk.sv
// Assertion checker for the MAC lane, bound to the top module.
// It follows final-beat flags through its own delay line to police result timing.
module mac_lane_chk #(
    parameter int DW  = 16,
    parameter int LAT = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          grp_last,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);
    logic [LAT:0] pend;

    // Delay line of final-beat flags, one entry per cycle of lane latency.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= {pend[LAT-1:0], grp_last};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == pend[LAT]);

    // R4
    idle_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !grp_last);

    // R7
    nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_data[DW-1]);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

bind conv_mac_lane mac_lane_chk #(.DW(DW), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .grp_last  (grp_last),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/conv_mac_lane_bench.sv
module conv_mac_lane_bench;
    localparam int CLK_P = 10;
    localparam int MS    = 4;
    localparam int DW    = 16;
    localparam int FRAC  = 8;
    localparam int NP    = MS * MS;
    localparam int LAT   = $clog2(NP) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NP*DW-1:0]  in_wgt = '0;
    logic [NP*DW-1:0]  in_feat = '0;
    logic [NP-1:0]     in_mask = '0;
    logic [7:0]        acc_len = '0;
    logic [DW-1:0]     bias = '0;
    logic [DW-1:0]     shortcut = '0;
    logic [DW-1:0]     act_ceil = '0;
    logic              out_valid;
    logic [DW-1:0]     out_data;

    conv_mac_lane u_conv_mac_lane (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wgt(in_wgt),
        .in_feat(in_feat), .in_mask(in_mask), .acc_len(acc_len), .bias(bias),
        .shortcut(shortcut), .act_ceil(act_ceil), .out_valid(out_valid),
        .out_data(out_data)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    int    exp_val [0:1023];
    int    exp_cyc [0:1023];
    string exp_req [0:1023];
    int wv [0:NP-1];
    int fv [0:NP-1];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Compare every result against the queue of expected values and cycles.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd_idx >= wr_idx) begin
                check(1'b0, "R8 unexpected result", longint'(out_data), -1);
            end else begin
                check(out_data == exp_val[rd_idx][DW-1:0], exp_req[rd_idx],
                      longint'(out_data), longint'(exp_val[rd_idx]));
                check(cyc == exp_cyc[rd_idx], "R9 latency (cycle)",
                      longint'(cyc), longint'(exp_cyc[rd_idx]));
                rd_idx++;
            end
        end
    end

    function automatic int rnd(input int amp);
        return int'($urandom_range(0, 2*amp)) - amp;
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b0;
            in_wgt   = {NP{16'hBEEF}};
            in_feat  = {NP{16'h7FFF}};
            in_mask  = '1;
            acc_len  = 8'($urandom_range(0, 255));
            bias     = 16'h7FFF;
            shortcut = 16'h7FFF;
            act_ceil = 16'h7FFF;
            @(negedge clk);
        end
    endtask

    // One group: mmode 0 full mask, 1 random, 2 empty; preset uses wv/fv as set.
    task automatic run_group(input int len, input int amp, input int mmode, input bit preset,
                             input int gap, input int b, input int s, input int c,
                             input string req);
        longint acc = 0;
        longint tot;
        longint cx;
        int nb = (len == 0) ? 1 : len;
        for (int k = 0; k < nb; k++) begin
            logic [NP-1:0] m;
            m = (mmode == 0) ? '1 : (mmode == 1) ? NP'($urandom) : '0;
            for (int i = 0; i < NP; i++) begin
                if (!preset) begin
                    wv[i] = rnd(amp);
                    fv[i] = rnd(amp);
                end
                if (m[i]) begin
                    acc += longint'(wv[i]) * longint'(fv[i]);
                    in_wgt[i*DW +: DW]  = wv[i][DW-1:0];
                    in_feat[i*DW +: DW] = fv[i][DW-1:0];
                end else begin
                    in_wgt[i*DW +: DW]  = 16'h7FFF;
                    in_feat[i*DW +: DW] = 16'h7FFF;
                end
            end
            in_valid = 1'b1;
            in_mask  = m;
            acc_len  = (k == 0) ? 8'(len) : 8'($urandom_range(0, 255));
            if (k == nb - 1) begin
                bias = b[DW-1:0]; shortcut = s[DW-1:0]; act_ceil = c[DW-1:0];
                tot = acc + (longint'(b) <<< FRAC) + (longint'(s) <<< FRAC);
                cx  = longint'(c) <<< FRAC;
                if (tot < 0) tot = 0;
                else if (tot > cx) tot = cx;
                exp_val[wr_idx] = int'(tot / 256);
                exp_cyc[wr_idx] = cyc + 1 + LAT;
                exp_req[wr_idx] = req;
                wr_idx++;
            end else begin
                bias = 16'h7FFF; shortcut = 16'h8000; act_ceil = 16'h0001;
            end
            @(negedge clk);
            if (gap > 0) idle(gap);
        end
    endtask

    task automatic drain(input string req);
        idle(LAT + 4);
        check(rd_idx == wr_idx, req, longint'(rd_idx), longint'(wr_idx));
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
        check(out_data == '0, "R1 out_data after reset", longint'(out_data), 0);

        // R2 R3 R8: every length 1..20, full mask, moderate data, wide ceiling
        for (int L = 1; L <= 20; L++) run_group(L, 300, 0, 0, 0, rnd(50), 0, 32767, "R2 R3 full-mask sum");
        drain("R8 result count");

        // R2: random and empty masks with junk in masked pairs
        for (int n = 0; n < 30; n++) run_group(int'($urandom_range(1, 6)), 300, 1, 0, 0, rnd(20), 0, 32767, "R2 random mask");
        run_group(3, 300, 2, 0, 0, 5, 0, 32767, "R2 empty mask");
        drain("R8 result count");

        // R3: zero length counts as one; maximum length 255
        for (int n = 0; n < 4; n++) run_group(0, 300, 0, 0, 0, 0, 0, 32767, "R3 zero length");
        run_group(255, 4096, 0, 0, 0, 0, 0, 32767, "R3 max length");
        drain("R8 result count");

        // R4: idle gaps with junk between beats
        for (int n = 0; n < 10; n++) run_group(int'($urandom_range(1, 5)), 300, 0, 0, n % 3 + 1, rnd(10), rnd(10), 32767, "R4 gaps ignored");
        drain("R8 result count");

        // R5: bias and shortcut on final beat only (junk on earlier beats)
        for (int n = 0; n < 10; n++) run_group(int'($urandom_range(2, 4)), 200, 0, 0, 0, rnd(200), rnd(200), 32767, "R5 bias shortcut");
        drain("R8 result count");

        // R6: 8.0 plus shortcut -3.0 under ceiling 6.0 gives 5.0 (1280)
        for (int i = 0; i < NP; i++) begin wv[i] = 0; fv[i] = 0; end
        wv[0] = 2048; fv[0] = 256;
        run_group(1, 0, 0, 1, 0, 0, -768, 1536, "R6 residual before clamp");
        // R7: negative to zero, overflow to ceiling, ceiling zero
        wv[0] = -2048;
        run_group(1, 0, 0, 1, 0, 0, 0, 1536, "R7 negative clamps to 0");
        wv[0] = 4096;
        run_group(1, 0, 0, 1, 0, 0, 0, 1536, "R7 high clamps to ceiling");
        run_group(1, 0, 0, 1, 0, 0, 0, 0, "R7 zero ceiling");
        for (int n = 0; n < 20; n++) run_group(int'($urandom_range(1, 3)), 2000, 1, 0, 0, rnd(3000), rnd(3000), int'($urandom_range(0, 3000)), "R7 random clamp");
        drain("R8 result count");

        // R10: back-to-back groups of changing length
        for (int n = 0; n < 15; n++) run_group(int'($urandom_range(1, 4)), 500, 0, 0, 0, rnd(30), rnd(30), 32767, "R10 back-to-back");
        drain("R8 result count");

        // R1: reset mid-group discards the partial sum
        begin
            int base_rd;
            run_group(5, 500, 0, 0, 0, 0, 0, 32767, "R1 aborted");
            wr_idx--;
        end
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        run_group(2, 300, 0, 0, 0, 1, 0, 32767, "R1 fresh after reset");
        drain("R1 R8 result count");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule